// File: doc/BRIEF.md
# Seconds Countdown Timer on an 8-bit Peripheral Bus

This block is a one-shot interval timer for a small processor that talks to its peripherals over an 8-bit address and data bus with separate read and write strobes. It takes up a window of four byte addresses. Software loads a whole number of seconds into the count register, which also starts the timer. It then reads the status register in a loop until the busy bit drops.

A prescaler turns the system clock into one tick per second. The prescaler restarts from zero on every load, so the first second of an interval is always a full second. The remaining seconds can be read back at any time. There is no interrupt, no automatic reload and no compare logic. The only way to see that the interval has ended is the polled busy bit.

Top module: `sec_countdown_timer`

## Requirements
- R1: After reset the timer is idle. A read of the status register (offset 0) returns 0x00, and a read of the count register (offset 2) returns 0x00.
- R2: Only addresses whose bits 7:2 match `BASE_ADDR` (default 0x04..0x07) are decoded. A write outside the window does not start the timer. A read outside the window, or any cycle with `bus_rd` low, drives 0x00 on `bus_rdata`.
- R3: A write to offset 2 (default address 0x06) with a nonzero value loads that value as the seconds count. From the next cycle, status bit 0 (busy) reads 1.
- R4: After a nonzero load of C, busy reads 1 for exactly C × `CLK_HZ` clock cycles, counted from the clock edge that samples the write.
- R5: Busy falls on the same edge at which the count reaches zero. It then stays 0 until the next load.
- R6: A load of 0 leaves busy at 0, and this also holds when the load arrives while a countdown is running.
- R7: A load while busy replaces the count and clears the prescaler. The new interval is timed in full from that write.
- R8: Status bits 7:1 always read 0. Reads of offsets 1 and 3 return 0x00.
- R9: A read of offset 2 returns the number of whole seconds still left. This value drops by one at each second tick.
- R10: Writes to offsets 0, 1 and 3 change neither busy nor the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by `CLK_HZ` |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Peripheral bus address |
| bus_wdata | input | 8 | Write data from the processor |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address and state |

## Verification
The hardest case to reach is a reload that lands partway through a second. The prescaler must be seen to restart, and not just the count. The bench loads three seconds and lets a part-second run. It then loads one second and counts the busy cycles after the second write, which must come to exactly one prescaler period. The bench sets `CLK_HZ` to 10 so that it can check whole intervals cycle by cycle, including the single cycle on which busy falls.

// File: rtl/sec_countdown_timer.sv
module sec_countdown_timer #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter logic [7:0]  BASE_ADDR = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);
  localparam int unsigned PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_HZ - 1);

  logic          busy;
  logic [7:0]    secs;
  logic [PW-1:0] pre;

  wire       in_win = (bus_addr[7:2] == BASE_ADDR[7:2]);
  wire [1:0] ofs    = bus_addr[1:0];
  wire       load   = bus_wr && in_win && (ofs == 2'd2);
  wire       tick   = busy && (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      secs <= '0;
      pre  <= '0;
    end else if (load) begin
      secs <= bus_wdata;
      busy <= (bus_wdata != 8'd0);
      pre  <= '0;
    end else if (tick) begin
      pre  <= '0;
      secs <= secs - 8'd1;
      if (secs == 8'd1) busy <= 1'b0;
    end else if (busy) begin
      pre <= pre + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd && in_win) begin
      case (ofs)
        2'd0:    bus_rdata = {7'b0, busy};
        2'd2:    bus_rdata = secs;
        default: bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/sec_countdown_timer_chk.sv
module sec_countdown_timer_chk #(
  parameter logic [7:0] BASE_ADDR = 8'h04
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       busy,
  input logic [7:0] secs
);
  wire hit  = (bus_addr[7:2] == BASE_ADDR[7:2]);
  wire ld   = bus_wr && hit && (bus_addr[1:0] == 2'd2);

  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && bus_wdata != 8'd0) |=> (busy && secs == $past(bus_wdata)));

  // R6
  zero_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && bus_wdata == 8'd0) |=> !busy);

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld) |=> !busy);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld) |=> (secs == $past(secs) || secs == $past(secs) - 8'd1));

  // R8
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit && bus_addr[1:0] == 2'd0) |-> (bus_rdata == {7'b0, busy}));

  // R2
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !hit) |-> (bus_rdata == 8'h00));
endmodule

bind sec_countdown_timer sec_countdown_timer_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .busy(busy), .secs(secs)
);

// File: tb/sec_countdown_timer_bench.sv
module sec_countdown_timer_bench;
  localparam int N = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_rdata;

  int compared = 0, mismatched = 0;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb[$];

  sec_countdown_timer #(.CLK_HZ(N), .BASE_ADDR(8'h04)) u_sec_countdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && bus_rd && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compared++;
      if (bus_rdata !== it.exp) begin
        mismatched++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", it.req, bus_addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    sb.push_back('{exp, req});
    bus_addr = a; bus_rd = 1;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(8'h04, 8'h00, "R1");
    rd(8'h06, 8'h00, "R1");
    // R8 unused offsets
    rd(8'h05, 8'h00, "R8");
    rd(8'h07, 8'h00, "R8");
    // R2 writes outside window ignored, reads outside return zero
    wr(8'h02, 8'h05);
    wr(8'h0A, 8'h05);
    rd(8'h04, 8'h00, "R2");
    rd(8'h06, 8'h00, "R2");
    rd(8'h0A, 8'h00, "R2");
    // R3 R4 R5 two-second interval, busy for exactly 2*N cycles
    wr(8'h06, 8'h02);
    for (int i = 0; i < 2*N + 5; i++)
      rd(8'h04, (i < 2*N) ? 8'h01 : 8'h00, "R4");
    // R5 stays idle afterwards
    for (int i = 0; i < 3*N; i++) rd(8'h04, 8'h00, "R5");
    // R9 remaining count
    wr(8'h06, 8'h03);
    for (int i = 0; i < 3*N + 2; i++)
      rd(8'h06, (i < 3*N) ? 8'(3 - i / N) : 8'h00, "R9");
    // R6 zero load
    wr(8'h06, 8'h00);
    rd(8'h04, 8'h00, "R6");
    wr(8'h06, 8'h04);
    rd(8'h04, 8'h01, "R3");
    wr(8'h06, 8'h00);
    rd(8'h04, 8'h00, "R6");
    rd(8'h06, 8'h00, "R6");
    // R7 reload mid-second restarts prescaler
    wr(8'h06, 8'h03);
    for (int i = 0; i < N + 4; i++) rd(8'h05, 8'h00, "R8");
    wr(8'h06, 8'h01);
    for (int i = 0; i < N + 3; i++)
      rd(8'h04, (i < N) ? 8'h01 : 8'h00, "R7");
    // R10 writes to other offsets ignored
    wr(8'h04, 8'h07);
    wr(8'h05, 8'h07);
    wr(8'h07, 8'h07);
    rd(8'h04, 8'h00, "R10");
    rd(8'h06, 8'h00, "R10");
    wr(8'h06, 8'h02);
    wr(8'h07, 8'h09);
    wr(8'h04, 8'h00);
    rd(8'h06, 8'h02, "R10");
    rd(8'h04, 8'h01, "R10");
    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule